// File: doc/BRIEF.md
# Eight-Context Thread Scheduler

This block keeps the run state of the hardware threads of one processing engine and decides which of them owns the pipeline. Each thread context holds three values: a resume program counter, a set of pending event bits and a wake mask. Software reaches these values indirectly. It first writes a context number into a selector register. The per-context registers it then reads or writes belong to the selected thread.

A thread is in one of four states: idle, waiting for an event, ready to run, or running. At most one thread runs at a time. When no thread runs, the scheduler picks the next ready thread whose enable bit is set. It searches round-robin, starting just after the thread that ran last. The running thread keeps the pipeline until the pipeline reports a yield or a kill. Clearing its enable bit does not stop it. A yield saves the resume address from the pipeline. The thread then waits, or goes straight back to ready if its wake condition already holds. A kill makes the thread idle.

Software uses the block to load start addresses, arm each thread through its wake mask and then set enable bits. The pipeline uses the running-thread number and its program counter to fetch instructions.

Top module: `thread_ctx_sched`

## Requirements
- R1: After synchronous reset, all contexts are idle (state code 0) with PC 0 and all enable bits clear. No context runs, and the read data is 0.
- R2: Offset 0x018 holds the per-context enable bits at bits [15:8], bit 8 being context 0. The other bits read as 0.
- R3: The low bits of offset 0x020 select the context reached through offsets 0x040 (PC, with the state code at bits [25:24]), 0x048 (pending events) and 0x050 (wake mask). The selector reads back at 0x020. Reads return data one cycle after the address is presented.
- R4: A wake-mask write to a context that is not running moves it to ready (code 1) when its wake condition holds, and to waiting (code 3) otherwise. The wake condition holds when mask bit 0 is set or any mask bit matches a pending event.
- R5: When nothing runs, a context that is ready and enabled starts running on the following clock edge. The block then presents its number and PC.
- R6: Among ready and enabled contexts, the one chosen is the first found searching upward from the last context that ran, wrapping around. After reset the search starts at context 0.
- R7: Clearing the enable bit of the running context does not stop it. A ready context whose enable bit is clear is never started.
- R8: A yield ends the running context on the next edge and stores the pipeline's resume PC. The context becomes ready if its wake condition holds, counting events that arrive in the same cycle; otherwise it becomes waiting.
- R9: A kill ends the running context and leaves it idle. If a yield arrives in the same cycle, the kill wins and the PC is kept.
- R10: Offset 0x044 reads bit 31 as 1 while a context runs, and bits [2:0] as the running (or last-run) context.
- R11: Event bits for a context accumulate in its pending register, and a write to that register replaces them. A waiting context becomes ready on the edge at which an arriving event matches its wake mask.
- R12: A yield or kill that arrives while no context runs changes no context state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for bus_addr |
| sig_vld | input | 1 | Event delivery strobe |
| sig_ctx | input | CTX_W | Context receiving the events |
| sig_bits | input | SIG_W | Event bits delivered |
| yield_ev | input | 1 | Running context gives up the pipeline |
| yield_pc | input | PC_W | Resume address saved on yield |
| kill_ev | input | 1 | Running context terminates |
| exec_valid | output | 1 | A context is running |
| exec_ctx | output | CTX_W | Running (or last-run) context |
| exec_pc | output | PC_W | PC of the context when it was started |

## Verification
Two pairs of events can fall in the same clock cycle. A yield can coincide with an event arriving for the same context. A kill can coincide with a yield. The bench drives each pair on one edge. In the first case it judges the result by whether the context is started again at the stored resume address one idle cycle later. In the second case it checks that the context stays off the pipeline and reads back as idle with its old PC. Seeded random enable and ready masks then exercise the round-robin order against a bench function.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;
  typedef enum logic [1:0] {
    CTX_IDLE = 2'd0,
    CTX_RDY  = 2'd1,
    CTX_RUN  = 2'd2,
    CTX_WAIT = 2'd3
  } ctx_state_t;

  localparam int OFS_EN   = 'h018;
  localparam int OFS_SEL  = 'h020;
  localparam int OFS_PC   = 'h040;
  localparam int OFS_STAT = 'h044;
  localparam int OFS_SIG  = 'h048;
  localparam int OFS_WAKE = 'h050;
endpackage

// File: rtl/ctx_rr_pick.sv
module ctx_rr_pick #(
  parameter int NCTX = 8,
  localparam int CW = $clog2(NCTX)
) (
  input  logic [NCTX-1:0] elig,
  input  logic [CW-1:0]   last,
  output logic            any,
  output logic [CW-1:0]   pick
);
  always_comb begin
    any  = 1'b0;
    pick = '0;
    // scan from farthest to nearest so the nearest eligible wins
    for (int k = NCTX; k >= 1; k--) begin
      int idx;
      idx = (int'(last) + k) % NCTX;
      if (elig[idx]) begin
        any  = 1'b1;
        pick = CW'(idx);
      end
    end
  end
endmodule

// File: rtl/ctx_slot.sv
module ctx_slot
  import ctx_sched_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int SIG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_pc,
  input  logic             wr_sig,
  input  logic             wr_wake,
  input  logic [PC_W-1:0]  wval_pc,
  input  logic [SIG_W-1:0] wval_sig,
  input  logic [SIG_W-1:0] sig_in,
  input  logic             grant,
  input  logic             yield_me,
  input  logic             kill_me,
  input  logic [PC_W-1:0]  yield_pc,
  output ctx_state_t       state_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [SIG_W-1:0] sig_o,
  output logic [SIG_W-1:0] wake_o
);
  ctx_state_t       st_q;
  logic [PC_W-1:0]  pc_q;
  logic [SIG_W-1:0] sig_q, wake_q, sig_eff;
  logic             met, met_w;

  always_comb begin
    sig_eff = sig_q | sig_in;
    met     = wake_q[0] | (|(wake_q & sig_eff));
    met_w   = wval_sig[0] | (|(wval_sig & sig_eff));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= CTX_IDLE;
      pc_q   <= '0;
      sig_q  <= '0;
      wake_q <= '0;
    end else begin
      sig_q <= wr_sig ? wval_sig : sig_eff;
      if (wr_wake) wake_q <= wval_sig;
      if (yield_me && !kill_me) pc_q <= yield_pc;
      else if (wr_pc)           pc_q <= wval_pc;
      if (kill_me)                           st_q <= CTX_IDLE;
      else if (yield_me)                     st_q <= met ? CTX_RDY : CTX_WAIT;
      else if (grant)                        st_q <= CTX_RUN;
      else if (wr_wake && st_q != CTX_RUN)   st_q <= met_w ? CTX_RDY : CTX_WAIT;
      else if (st_q == CTX_WAIT && met)      st_q <= CTX_RDY;
    end
  end

  assign state_o = st_q;
  assign pc_o    = pc_q;
  assign sig_o   = sig_q;
  assign wake_o  = wake_q;
endmodule

// File: rtl/thread_ctx_sched.sv
module thread_ctx_sched
  import ctx_sched_pkg::*;
#(
  parameter int NCTX   = 8,
  parameter int PC_W   = 12,
  parameter int SIG_W  = 16,
  parameter int ADDR_W = 10,
  localparam int CTX_W = $clog2(NCTX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              sig_vld,
  input  logic [CTX_W-1:0]  sig_ctx,
  input  logic [SIG_W-1:0]  sig_bits,
  input  logic              yield_ev,
  input  logic [PC_W-1:0]   yield_pc,
  input  logic              kill_ev,
  output logic              exec_valid,
  output logic [CTX_W-1:0]  exec_ctx,
  output logic [PC_W-1:0]   exec_pc
);
  logic [NCTX-1:0]  en_q;
  logic [CTX_W-1:0] sel_q, last_q, pick;
  logic [31:0]      rd_val, rdata_q;
  logic             run_q, any, want, yield_v, kill_v;
  logic [CTX_W-1:0] run_ctx_q;
  logic [PC_W-1:0]  run_pc_q;
  logic             wr_en, wr_sel, wr_pc, wr_sig, wr_wake;
  logic [NCTX-1:0]  elig;
  ctx_state_t       st_a   [NCTX];
  logic [PC_W-1:0]  pc_a   [NCTX];
  logic [SIG_W-1:0] sig_a  [NCTX];
  logic [SIG_W-1:0] wake_a [NCTX];
  logic             unused_wbits;

  assign unused_wbits = ^bus_wdata[31:16];

  always_comb begin
    wr_en   = bus_wr && bus_addr == ADDR_W'(OFS_EN);
    wr_sel  = bus_wr && bus_addr == ADDR_W'(OFS_SEL);
    wr_pc   = bus_wr && bus_addr == ADDR_W'(OFS_PC);
    wr_sig  = bus_wr && bus_addr == ADDR_W'(OFS_SIG);
    wr_wake = bus_wr && bus_addr == ADDR_W'(OFS_WAKE);
    yield_v = yield_ev && run_q;
    kill_v  = kill_ev && run_q;
    want    = !run_q && any;
  end

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    logic mine, run_me;
    assign mine   = sel_q == CTX_W'(i);
    assign run_me = run_ctx_q == CTX_W'(i);
    assign elig[i] = en_q[i] && st_a[i] == CTX_RDY;
    ctx_slot #(.PC_W(PC_W), .SIG_W(SIG_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .wr_pc    (wr_pc && mine),
      .wr_sig   (wr_sig && mine),
      .wr_wake  (wr_wake && mine),
      .wval_pc  (bus_wdata[PC_W-1:0]),
      .wval_sig (bus_wdata[SIG_W-1:0]),
      .sig_in   ((sig_vld && sig_ctx == CTX_W'(i)) ? sig_bits : '0),
      .grant    (want && pick == CTX_W'(i)),
      .yield_me (yield_v && run_me),
      .kill_me  (kill_v && run_me),
      .yield_pc (yield_pc),
      .state_o  (st_a[i]),
      .pc_o     (pc_a[i]),
      .sig_o    (sig_a[i]),
      .wake_o   (wake_a[i])
    );
  end

  ctx_rr_pick #(.NCTX(NCTX)) u_pick (
    .elig (elig),
    .last (last_q),
    .any  (any),
    .pick (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      sel_q     <= '0;
      last_q    <= CTX_W'(NCTX - 1);
      run_q     <= 1'b0;
      run_ctx_q <= '0;
      run_pc_q  <= '0;
    end else begin
      if (wr_en)  en_q  <= bus_wdata[8 +: NCTX];
      if (wr_sel) sel_q <= bus_wdata[CTX_W-1:0];
      if (yield_v || kill_v) begin
        run_q <= 1'b0;
      end else if (want) begin
        run_q     <= 1'b1;
        run_ctx_q <= pick;
        run_pc_q  <= pc_a[pick];
        last_q    <= pick;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == ADDR_W'(OFS_EN)) rd_val[8 +: NCTX] = en_q;
    else if (bus_addr == ADDR_W'(OFS_SEL)) rd_val[CTX_W-1:0] = sel_q;
    else if (bus_addr == ADDR_W'(OFS_PC)) begin
      rd_val[PC_W-1:0] = pc_a[sel_q];
      rd_val[25:24]    = st_a[sel_q];
    end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
      rd_val[31]        = run_q;
      rd_val[CTX_W-1:0] = run_ctx_q;
    end else if (bus_addr == ADDR_W'(OFS_SIG))  rd_val[SIG_W-1:0] = sig_a[sel_q];
    else if (bus_addr == ADDR_W'(OFS_WAKE)) rd_val[SIG_W-1:0] = wake_a[sel_q];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_val;
  end

  assign bus_rdata  = rdata_q;
  assign exec_valid = run_q;
  assign exec_ctx   = run_ctx_q;
  assign exec_pc    = run_pc_q;
endmodule

// File: rtl/thread_ctx_sched_chk.sv
module thread_ctx_sched_chk #(
  parameter int NCTX   = 8,
  parameter int PC_W   = 12,
  parameter int ADDR_W = 10,
  localparam int CTX_W = $clog2(NCTX)
) (
  input logic              clk,
  input logic              rst,
  input logic              yield_ev,
  input logic              kill_ev,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              exec_valid,
  input logic [CTX_W-1:0]  exec_ctx,
  input logic [PC_W-1:0]   exec_pc,
  input logic [NCTX-1:0]   en
);
  logic [NCTX-1:0] en_d;
  always_ff @(posedge clk) en_d <= en;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!exec_valid && exec_pc == '0 && bus_rdata == '0));

  // R8
  end_on_event_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && (yield_ev || kill_ev)) |=> !exec_valid);

  // R7
  run_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && !yield_ev && !kill_ev) |=>
      (exec_valid && $stable(exec_ctx) && $stable(exec_pc)));

  // R5
  start_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(exec_valid) |-> en_d[exec_ctx]);

  // R10
  status_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'('h44)) |=> (bus_rdata[31] == $past(exec_valid)));
endmodule

bind thread_ctx_sched thread_ctx_sched_chk #(
  .NCTX(NCTX), .PC_W(PC_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .yield_ev   (yield_ev),
  .kill_ev    (kill_ev),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .exec_valid (exec_valid),
  .exec_ctx   (exec_ctx),
  .exec_pc    (exec_pc),
  .en         (en_q)
);

// File: tb/test_thread_ctx_sched.sv
`timescale 1ns/1ps
module test_thread_ctx_sched;
  localparam int NCTX = 8, PC_W = 12, SIG_W = 16, ADDR_W = 10, CW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sig_vld = 1'b0;
  logic [CW-1:0] sig_ctx = '0;
  logic [SIG_W-1:0] sig_bits = '0;
  logic yield_ev = 1'b0, kill_ev = 1'b0;
  logic [PC_W-1:0] yield_pc = '0;
  logic exec_valid;
  logic [CW-1:0] exec_ctx;
  logic [PC_W-1:0] exec_pc;

  int checks = 0, fails = 0;
  logic [CW-1:0] last_m;
  logic [PC_W-1:0] pc_m [NCTX];
  logic [31:0] d;

  thread_ctx_sched #(.NCTX(NCTX), .PC_W(PC_W), .SIG_W(SIG_W), .ADDR_W(ADDR_W)) i_thread_ctx_sched (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sig_vld(sig_vld), .sig_ctx(sig_ctx), .sig_bits(sig_bits),
    .yield_ev(yield_ev), .yield_pc(yield_pc), .kill_ev(kill_ev),
    .exec_valid(exec_valid), .exec_ctx(exec_ctx), .exec_pc(exec_pc));

  always #2.5 clk = ~clk;

  function automatic logic [CW-1:0] rr_next(logic [CW-1:0] last, logic [NCTX-1:0] elig);
    for (int k = NCTX; k >= 1; k--)
      if (elig[(int'(last) + k) % NCTX]) rr_next = CW'((int'(last) + k) % NCTX);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] v);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = v;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    bus_addr = ADDR_W'(a);
    tick();
    v = bus_rdata;
  endtask

  task automatic chk_rd(input int a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    chk(v == exp, req, v, exp);
  endtask

  task automatic chk_run(input logic [CW-1:0] c, input logic [PC_W-1:0] p, input string req);
    chk(exec_valid && exec_ctx == c && exec_pc == p, req,
        {exec_valid, 15'd0, 1'b0, exec_ctx, exec_pc}, {1'b1, 15'd0, 1'b0, c, p});
  endtask

  task automatic chk_idle(input string req);
    chk(!exec_valid, req, {31'd0, exec_valid}, 32'd0);
  endtask

  initial begin
    #500us;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(!exec_valid && exec_pc == 0 && bus_rdata == 0, "R1", {exec_valid, exec_pc}, 0);
    chk_rd('h018, 0, "R1 enables");
    chk_rd('h040, 0, "R1 ctx0 idle pc0");
    chk_rd('h044, 0, "R10 idle status");
    last_m = CW'(NCTX - 1);
    // R3 selector and indirect access
    wr('h020, 3);
    chk_rd('h020, 3, "R3");
    wr('h040, 'h155);
    // R4 wake mask without met condition -> waiting
    wr('h050, 'h2);
    chk_rd('h040, 32'h0300_0155, "R4 waiting");
    chk_rd('h050, 'h2, "R3 wake readback");
    // R11 event wakes waiting context
    sig_vld = 1'b1; sig_ctx = 3; sig_bits = 'h2;
    tick();
    sig_vld = 1'b0;
    chk_rd('h040, 32'h0100_0155, "R11 ready");
    chk_rd('h048, 'h2, "R11 pending");
    chk_idle("R7 disabled not started");
    // R2 / R5 enable and start
    wr('h018, 32'h0000_0800);
    chk_idle("R5 start latency");
    tick();
    chk_run(3, 'h155, "R5");
    last_m = 3;
    chk_rd('h044, 32'h8000_0003, "R10");
    chk_rd('h018, 32'h0000_0800, "R2");
    wr('h018, 32'hFFFF_00FF);
    chk_rd('h018, 32'h0, "R2 other bits");
    // R7 running context keeps going though disabled
    tick(); tick();
    chk_run(3, 'h155, "R7 no preempt");
    // R8 yield with condition met -> ready, not restarted (disabled)
    yield_ev = 1'b1; yield_pc = 'h200;
    tick();
    yield_ev = 1'b0;
    chk_idle("R8 yield ends");
    chk_rd('h040, 32'h0100_0200, "R8 ready after yield");
    chk_idle("R7 ready disabled");
    // R8 yield without condition -> waiting
    wr('h048, 0);
    wr('h018, 32'h0000_0800);
    tick();
    chk_run(3, 'h200, "R5 restart");
    yield_ev = 1'b1; yield_pc = 'h210;
    tick();
    yield_ev = 1'b0;
    chk_rd('h040, 32'h0300_0210, "R8 waiting after yield");
    sig_vld = 1'b1; sig_bits = 'h2;
    tick();
    sig_vld = 1'b0;
    chk_idle("R11 wake edge");
    tick();
    chk_run(3, 'h210, "R11 woken then started");
    wr('h048, 0);
    // R8 yield and matching event in the same cycle
    yield_ev = 1'b1; yield_pc = 'h321; sig_vld = 1'b1; sig_bits = 'h2;
    tick();
    yield_ev = 1'b0; sig_vld = 1'b0;
    chk_idle("R8 same-cycle");
    tick();
    chk_run(3, 'h321, "R8 same-cycle event counts");
    // R9 kill beats yield
    kill_ev = 1'b1; yield_ev = 1'b1; yield_pc = 'h3AA;
    tick();
    kill_ev = 1'b0; yield_ev = 1'b0;
    tick(); tick();
    chk_idle("R9 stays off");
    chk_rd('h040, 32'h0000_0321, "R9 idle pc kept");
    // R12 events ignored when nothing runs
    wr('h020, 5);
    wr('h050, 1);
    kill_ev = 1'b1; yield_ev = 1'b1;
    tick();
    kill_ev = 1'b0; yield_ev = 1'b0;
    chk_rd('h040, 32'h0100_0000, "R12");
    chk_idle("R12 no run");

    // R6 random round-robin trials
    for (int t = 0; t < 20; t++) begin
      logic [NCTX-1:0] rmask, emask;
      rmask = NCTX'($urandom);
      emask = NCTX'($urandom);
      if ((rmask & emask) == 0) begin
        rmask[t % NCTX] = 1'b1;
        emask[t % NCTX] = 1'b1;
      end
      wr('h018, 0);
      for (int i = 0; i < NCTX; i++) begin
        wr('h020, i);
        wr('h048, 0);
        pc_m[i] = PC_W'($urandom);
        wr('h040, {20'd0, pc_m[i]});
        wr('h050, {31'd0, rmask[i]});
      end
      wr('h018, {16'd0, emask, 8'd0});
      for (int g = 0; g < 6; g++) begin
        logic [CW-1:0] exp_c;
        exp_c = rr_next(last_m, rmask & emask);
        tick();
        chk_run(exp_c, pc_m[exp_c], "R6 round-robin");
        last_m = exp_c;
        if (g < 5) begin
          yield_pc = PC_W'($urandom);
          pc_m[exp_c] = yield_pc;
          yield_ev = 1'b1;
          tick();
          yield_ev = 1'b0;
        end else begin
          wr('h018, 0);
          chk_run(exp_c, pc_m[exp_c], "R7 disable while running");
          kill_ev = 1'b1;
          tick();
          kill_ev = 1'b0;
        end
        chk_idle("R8 idle after end");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule